// File: doc/BRIEF.md
# Windowed Error-Count Audio Source Selector

This block watches the quality of a digital stereo sound stream by counting the parity-error pulses its decoder emits, one pulse per bad sample, over fixed windows of 128 ms. At the close of each window the count is published as an 8-bit error figure. That figure is compared with two programmable limits. A count above the upper limit moves the audio source away from the digital stream. A count below the lower limit moves it back. A count between the limits leaves the source as it is, so a stream near one limit does not make the source toggle.

When the digital stream is dropped, the source becomes a fallback. The fallback is either the first analog sound carrier or the analog mono input, set by one select bit. A bypass bit turns off error-driven switching, so the digital stream stays selected. A missing digital stream always forces the first sound carrier. The window is built from a clock-enable prescaler. One parameter sets the clock cycles per millisecond tick and another sets the ticks per window.

Top module: `err_hyst_mute`

## Requirements
- R1: Error pulses are counted over windows of exactly TICK_DIV*WIN_TICKS clock cycles, starting from reset release. A pulse in any cycle of a window, the last cycle included, counts toward that window. `err_byte` takes the window's count on the clock edge that closes the window and is stable at all other times.
- R2: The window count saturates at 255. A window with more than 255 pulses publishes 255.
- R3: A closed window whose count is strictly greater than `lim_hi` sets the fallback state.
- R4: A closed window whose count is strictly less than `lim_lo` clears the fallback state, which restores the digital stream.
- R5: A closed window whose count lies in the range `lim_lo` to `lim_hi`, both ends included, leaves the fallback state unchanged.
- R6: `src_sel` encodes the source: 00 is the digital stream, 01 is the first sound carrier, 10 is the analog mono input. Code 11 never appears. With the digital stream present, auto-switching enabled and the fallback state set, `src_sel` is 10 when `alt_mono_sel` is 1 and 01 when it is 0.
- R7: With `auto_bypass` = 1 and the digital stream present, `src_sel` is 00 whatever the error counts are.
- R8: With `nic_present` = 0, `src_sel` is 01, whatever the other controls and the fallback state are.
- R9: In reset, `err_byte` is 0 and the fallback state is set. The fallback therefore stays selected until the first closed window with a count below `lim_lo`.
- R10: `muted` is 1 exactly when the digital stream is present, `auto_bypass` is 0 and the fallback state is set.
- R11: The fallback state changes only on a window-closing edge. It keeps tracking window counts while bypassed, so clearing `auto_bypass` applies the latest decision at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_pulse | input | 1 | One-cycle pulse per sample with a parity error |
| nic_present | input | 1 | Digital sound stream detected |
| auto_bypass | input | 1 | 1 disables error-driven switching |
| alt_mono_sel | input | 1 | Fallback target: 1 = analog mono input, 0 = first sound carrier |
| lim_hi | input | 8 | Upper error limit |
| lim_lo | input | 8 | Lower error limit |
| src_sel | output | 2 | Selected audio source code |
| err_byte | output | 8 | Error count of the last closed window |
| muted | output | 1 | Digital stream suppressed by the error logic |

## Verification
`err_byte` and the fallback state are registered. Both change on the edge that ends a window, which is clock edge W·n after reset release, where W = TICK_DIV*WIN_TICKS. The bench drives each window as exactly W falling-edge steps and reads `err_byte` at the falling edge that follows the closing edge. `src_sel` and `muted` follow the controls without a register. The bench changes a control at a falling edge and samples those outputs one nanosecond later. It also reads the outputs partway through a window, to confirm that nothing has moved before the window closes.

// File: rtl/ehm_pkg.sv
package ehm_pkg;
    typedef enum logic [1:0] {
        SRC_DIGITAL  = 2'b00,
        SRC_CARRIER1 = 2'b01,
        SRC_MONO     = 2'b10
    } src_e;
endpackage

// File: rtl/ehm_window.sv
module ehm_window #(
    parameter int TICK_DIV  = 18432,
    parameter int WIN_TICKS = 128
) (
    input  logic clk,
    input  logic rst_n,
    output logic win_end
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam int WW = (WIN_TICKS > 1) ? $clog2(WIN_TICKS) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);
    localparam logic [WW-1:0] WIN_LAST = WW'(WIN_TICKS - 1);

    typedef struct packed {
        logic [PW-1:0] pre;
        logic [WW-1:0] win;
    } win_st_t;

    win_st_t st_d, st_q;
    logic    tick;

    always_comb begin
        st_d    = st_q;
        tick    = (st_q.pre == PRE_LAST);
        win_end = tick && (st_q.win == WIN_LAST);
        if (tick) begin
            st_d.pre = '0;
            st_d.win = win_end ? '0 : st_q.win + 1'b1;
        end else begin
            st_d.pre = st_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/ehm_err_count.sv
module ehm_err_count #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          err_pulse,
    input  logic          win_end,
    output logic [CW-1:0] cnt_fin,
    output logic [CW-1:0] err_byte
);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    typedef struct packed {
        logic [CW-1:0] run;
        logic [CW-1:0] pub;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        cnt_fin = (st_q.run == CNT_MAX) ? CNT_MAX : st_q.run + CW'(err_pulse);
        if (win_end) begin
            st_d.pub = cnt_fin;
            st_d.run = '0;
        end else begin
            st_d.run = cnt_fin;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err_byte = st_q.pub;
endmodule

// File: rtl/ehm_hyst.sv
module ehm_hyst #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          win_end,
    input  logic [CW-1:0] cnt_fin,
    input  logic [CW-1:0] lim_hi,
    input  logic [CW-1:0] lim_lo,
    output logic          fb_q
);
    typedef struct packed {
        logic fb;
    } hy_st_t;

    hy_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (win_end) begin
            if (cnt_fin > lim_hi)      st_d.fb = 1'b1;
            else if (cnt_fin < lim_lo) st_d.fb = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{fb: 1'b1};
        else        st_q <= st_d;
    end

    assign fb_q = st_q.fb;
endmodule

// File: rtl/err_hyst_mute.sv
module err_hyst_mute #(
    parameter int TICK_DIV  = 18432,
    parameter int WIN_TICKS = 128,
    parameter int CW        = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          err_pulse,
    input  logic          nic_present,
    input  logic          auto_bypass,
    input  logic          alt_mono_sel,
    input  logic [CW-1:0] lim_hi,
    input  logic [CW-1:0] lim_lo,
    output logic [1:0]    src_sel,
    output logic [CW-1:0] err_byte,
    output logic          muted
);
    import ehm_pkg::*;

    logic          win_end;
    logic [CW-1:0] cnt_fin;
    logic          fb_q;
    src_e          src_d;

    ehm_window #(.TICK_DIV(TICK_DIV), .WIN_TICKS(WIN_TICKS)) u_win (
        .clk(clk), .rst_n(rst_n), .win_end(win_end)
    );

    ehm_err_count #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .err_pulse(err_pulse), .win_end(win_end),
        .cnt_fin(cnt_fin), .err_byte(err_byte)
    );

    ehm_hyst #(.CW(CW)) u_hys (
        .clk(clk), .rst_n(rst_n), .win_end(win_end), .cnt_fin(cnt_fin),
        .lim_hi(lim_hi), .lim_lo(lim_lo), .fb_q(fb_q)
    );

    always_comb begin
        if (!nic_present)          src_d = SRC_CARRIER1;
        else if (auto_bypass)      src_d = SRC_DIGITAL;
        else if (!fb_q)            src_d = SRC_DIGITAL;
        else if (alt_mono_sel)     src_d = SRC_MONO;
        else                       src_d = SRC_CARRIER1;
        muted = nic_present && !auto_bypass && fb_q;
    end

    assign src_sel = src_d;
endmodule

// File: rtl/err_hyst_mute_chk.sv
module err_hyst_mute_chk #(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          win_end,
    input logic [CW-1:0] cnt_fin,
    input logic          fb_q,
    input logic          nic_present,
    input logic          auto_bypass,
    input logic [CW-1:0] lim_hi,
    input logic [CW-1:0] lim_lo,
    input logic [1:0]    src_sel,
    input logic [CW-1:0] err_byte
);
    AST_BYTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end |=> $stable(err_byte)); // R1
    AST_GO_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (win_end && cnt_fin > lim_hi) |=> fb_q); // R3
    AST_GO_DIGITAL: assert property (@(posedge clk) disable iff (!rst_n)
        (win_end && cnt_fin < lim_lo && cnt_fin <= lim_hi) |=> !fb_q); // R4
    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (win_end && cnt_fin >= lim_lo && cnt_fin <= lim_hi) |=> $stable(fb_q)); // R5
    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        src_sel != 2'b11); // R6
    AST_BYPASS_DIGITAL: assert property (@(posedge clk) disable iff (!rst_n)
        (nic_present && auto_bypass) |-> src_sel == 2'b00); // R7
    AST_ABSENT_CARRIER: assert property (@(posedge clk) disable iff (!rst_n)
        !nic_present |-> src_sel == 2'b01); // R8
    AST_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end |=> $stable(fb_q)); // R11
endmodule

bind err_hyst_mute err_hyst_mute_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .win_end(win_end), .cnt_fin(cnt_fin),
    .fb_q(fb_q), .nic_present(nic_present), .auto_bypass(auto_bypass),
    .lim_hi(lim_hi), .lim_lo(lim_lo), .src_sel(src_sel), .err_byte(err_byte)
);

// File: tb/sim_err_hyst_mute.sv
`timescale 1ns/1ps
module sim_err_hyst_mute;
    localparam int TD = 40;
    localparam int WT = 8;
    localparam int W  = TD * WT;
    localparam int VN = 9;
    localparam int V_ERR[VN] = '{10, 3, 15, 20, 21, 5, 4, 300, 0};
    localparam int V_HI [VN] = '{20, 20, 20, 20, 20, 20, 20, 200, 200};
    localparam int V_LO [VN] = '{5, 5, 5, 5, 5, 5, 5, 50, 50};
    localparam int V_BYT[VN] = '{10, 3, 15, 20, 21, 5, 4, 255, 0};
    localparam int V_FB [VN] = '{1, 0, 0, 0, 1, 1, 0, 1, 0};
    localparam string V_REQ[VN] = '{"R5/R9", "R4", "R5", "R5", "R3", "R5", "R4", "R2/R3", "R4"};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       err_pulse = 1'b0;
    logic       nic_present = 1'b1;
    logic       auto_bypass = 1'b0;
    logic       alt_mono_sel = 1'b0;
    logic [7:0] lim_hi = 8'd20;
    logic [7:0] lim_lo = 8'd5;
    logic [1:0] src_sel;
    logic [7:0] err_byte;
    logic       muted;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    err_hyst_mute #(.TICK_DIV(TD), .WIN_TICKS(WT), .CW(8)) u0 (
        .clk(clk), .rst_n(rst_n), .err_pulse(err_pulse),
        .nic_present(nic_present), .auto_bypass(auto_bypass),
        .alt_mono_sel(alt_mono_sel), .lim_hi(lim_hi), .lim_lo(lim_lo),
        .src_sel(src_sel), .err_byte(err_byte), .muted(muted)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_cycles(input int n, input int pulses);
        for (int i = 0; i < n; i++) begin
            err_pulse = (i < pulses);
            @(negedge clk);
        end
        err_pulse = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R9 reset state
        chk("R9 err_byte", err_byte, 0);
        chk("R9 src_sel", src_sel, 1);
        chk("R10 muted", muted, 1);
        rst_n = 1'b1;
        // table: each vector is one complete window
        for (int v = 0; v < VN; v++) begin
            lim_hi = 8'(V_HI[v]);
            lim_lo = 8'(V_LO[v]);
            run_cycles(W, V_ERR[v]);
            #1;
            chk({V_REQ[v], " R1 err_byte"}, err_byte, V_BYT[v]);
            chk({V_REQ[v], " src_sel"}, src_sel, V_FB[v] ? 1 : 0);
            chk("R10 muted", muted, V_FB[v]);
        end
        // R1/R11: nothing moves before the window closes
        run_cycles(250, 250);
        #1;
        chk("R1 mid-window err_byte", err_byte, 0);
        chk("R11 mid-window src_sel", src_sel, 0);
        run_cycles(W - 250, 0);
        #1;
        chk("R1 err_byte", err_byte, 250);
        chk("R3 src_sel", src_sel, 1);
        // R6 mono fallback target
        alt_mono_sel = 1'b1;
        #1;
        chk("R6 mono target", src_sel, 2);
        // R7/R10 bypass
        auto_bypass = 1'b1;
        #1;
        chk("R7 bypass src_sel", src_sel, 0);
        chk("R10 bypass muted", muted, 0);
        // R11 state tracks while bypassed
        @(negedge clk);
        run_cycles(W - 1, 0);
        #1;
        chk("R1 err_byte", err_byte, 0);
        auto_bypass = 1'b0;
        #1;
        chk("R11 tracked while bypassed", src_sel, 0);
        chk("R10 muted", muted, 0);
        // R8 absent stream forces first carrier
        @(negedge clk);
        run_cycles(W - 1, 300);
        #1;
        chk("R2 err_byte", err_byte, 255);
        chk("R6 mono target", src_sel, 2);
        nic_present = 1'b0;
        auto_bypass = 1'b1;
        #1;
        chk("R8 absent src_sel", src_sel, 1);
        chk("R10 absent muted", muted, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule